// File: doc/BRIEF.md
# Hook-Event Register Reprogramming Sequencer

This block runs on the host side of a telephone line interface. It keeps a write-only, volatile configuration device correctly programmed. The device loses every register whenever its supply collapses, which happens on power-up and on each hook change. It is also at risk during a flash or a line break. The block holds a shadow table with the intended 4-bit value of each register. It takes single-cycle event pulses from the surrounding logic. For each event it sends the matching series of 8-bit frames over a three-wire serial link: a clock, a data line and a latch strobe.

After power loss the block sends a restore-defaults command and then rewrites the whole table. Entry into handsfree is staged. The mode register is first written as handset, and the handsfree bit follows only after a programmable settling delay. Around a flash or a line break it raises a hold bit in the mode register and clears it afterwards. After the clear it rewrites the table once more. An optional timer rewrites the table at a fixed interval. Events that arrive while a sequence is running wait in a small priority queue, and duplicate events are merged.

Top module: `hook_reprog_seq`

## Requirements
- R1: A power-up or hook event produces the frame 0xF0 (restore-defaults command) and then one frame per register from address 4 up to 14 in ascending order. A frame is {addr[3:0], data[3:0]}. The data is the shadow value, except at the mode register (address 13), where bit 3 (hold) and bit 0 (handsfree) are both sent as 0.
- R2: The cause of a power-up or hook event is read from hook_mode at the event. The value 2'b10 means handsfree, and any other value means handset. For handsfree, one more mode-register frame with bit 0 = 1 follows the rewrite. Its first serial clock rise comes at least hf_delay + 2·H cycles after the previous latch rise, where H is the half period of R6.
- R3: A flash-start or line-break-start pulse produces one mode-register frame with bit 3 = 1. Bit 0 keeps the current mode and bits 2:1 come from the shadow table.
- R4: A flash-end or line-break-end pulse produces a mode-register frame with bit 3 = 0. Frames for addresses 4 to 14 follow, with no restore-defaults command, and the mode register in that list also carries bit 3 = 0 and the current mode.
- R5: Frames are sent MSB first. sdata changes only while sclk is low. A slatch pulse follows the eighth bit with sclk low. Exactly eight sclk rises occur per latch.
- R6: Each sclk high phase, each sclk low phase and each slatch pulse lasts H = max(clk_div, MIN_HALF-1)+1 system cycles. The default MIN_HALF = 10 keeps sclk at or below 5 MHz with a 100 MHz system clock.
- R7: With refresh_en high, the table (addresses 4 to 14, no restore-defaults command) is rewritten every refresh_interval cycles. The mode register in that rewrite carries the current hold bit and mode.
- R8: Pending events are served in this order: power-up, then hold-set, then hold-clear, then hook, then refresh. Repeated pulses of one kind give one sequence. A pending power-up absorbs a pending hook, and the latest hook_mode wins. A start pulse cancels a pending hold-clear.
- R9: busy is high from the start of a sequence until two cycles after its last latch pulse ends, and it stays high during the handsfree delay. sclk and slatch are low whenever busy is low.
- R10: A cfg_we write stores cfg_data at cfg_addr in the shadow table. It sends nothing and does not raise busy. The stored value is used by the next sequence.
- R11: After reset, busy, sclk, sdata and slatch are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Shadow table write strobe |
| cfg_addr | input | 4 | Shadow table address |
| cfg_data | input | 4 | Shadow table write value |
| clk_div | input | 8 | Serial half period minus one, in system cycles, clamped from below |
| hf_delay | input | 16 | Handsfree settling delay in system cycles |
| refresh_en | input | 1 | Enables periodic rewrite |
| refresh_interval | input | 20 | Periodic rewrite interval in system cycles |
| ev_powerup | input | 1 | Power-up event pulse |
| ev_hook | input | 1 | Hook-change event pulse |
| hook_mode | input | 2 | Hook state at the event: 2'b10 handsfree, other handset/on-hook |
| ev_flash_start | input | 1 | Flash begins |
| ev_flash_end | input | 1 | Line current restored after flash |
| ev_brk_start | input | 1 | Line break begins |
| ev_brk_end | input | 1 | Line restored after break |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| slatch | output | 1 | Frame latch strobe |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench fires events while another sequence is running. A queue without priority would emit the hold-set frame after the hook rewrite. A queue without merging would send the full rewrite twice. The bench sends a hold-clear followed by a start and expects the clear to vanish; a block that keeps it would send the table one time too many. The handsfree gap is measured in cycles, so a block that skips the settling delay sends the final mode frame far too early. The bench also sets a divider below the floor, and an unclamped clock then shows up as short high phases.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
   typedef enum logic [1:0] {
      SK_FULL    = 2'd0,
      SK_SET     = 2'd1,
      SK_CLR     = 2'd2,
      SK_REFRESH = 2'd3
   } seq_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_TX   = 2'd2,
      ST_HFW  = 2'd3
   } seq_state_e;

   // pending slots, lower index served first
   localparam int PK_PWR  = 0;
   localparam int PK_SET  = 1;
   localparam int PK_CLR  = 2;
   localparam int PK_HOOK = 3;
   localparam int PK_REF  = 4;
   localparam int PK_N    = 5;

   localparam logic [1:0] HM_HANDSFREE = 2'b10;
endpackage

// File: rtl/hrs_shadow.sv
module hrs_shadow #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 4
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    we_i,
   input  logic [ADDR_W-1:0]                       addr_i,
   input  logic [DATA_W-1:0]                       data_i,
   output logic [(1<<ADDR_W)-1:0][DATA_W-1:0]      tbl_o
);
   localparam int NREG = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tbl_o[g] <= '0;
            else if (we_i && (addr_i == ADDR_W'(g)))
               tbl_o[g] <= data_i;
         end
      end
   endgenerate
endmodule

// File: rtl/hrs_evq.sv
module hrs_evq #(
   parameter int NK = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NK-1:0] set_i,
   input  logic [NK-1:0] clr_i,
   output logic [NK-1:0] pend_o,
   output logic [NK-1:0] grant_o,
   output logic          any_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_o <= '0;
      else
         pend_o <= (pend_o & ~clr_i) | set_i;
   end

   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < NK; i++) begin
         if (pend_o[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
      any_o = found;
   end
endmodule

// File: rtl/hrs_tick.sv
module hrs_tick #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] interval_i,
   output logic             fire_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fire_o <= 1'b0;
      end else begin
         fire_o <= 1'b0;
         if (!en_i) begin
            cnt_q <= '0;
         end else if (cnt_q + CNT_W'(1) >= interval_i) begin
            cnt_q  <= '0;
            fire_o <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/hrs_sertx.sv
module hrs_sertx #(
   parameter int FW       = 8,
   parameter int DIV_W    = 8,
   parameter int MIN_HALF = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             start_i,
   input  logic [FW-1:0]    frame_i,
   output logic             sclk_o,
   output logic             sdata_o,
   output logic             slatch_o,
   output logic             done_o
);
   localparam int NHALF = 2 * FW;
   localparam int HW    = $clog2(NHALF + 2);
   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(MIN_HALF - 1);

   logic [FW-1:0]    shreg_q;
   logic [HW-1:0]    half_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] eff_div;
   logic             active_q;

   assign eff_div = (div_i < MIN_DIV) ? MIN_DIV : div_i;
   assign sdata_o = shreg_q[FW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         half_q   <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
         sclk_o   <= 1'b0;
         slatch_o <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            shreg_q  <= frame_i;
            half_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b1;
            sclk_o   <= 1'b0;
            slatch_o <= 1'b0;
         end else if (active_q) begin
            if (cnt_q == eff_div) begin
               cnt_q  <= '0;
               half_q <= half_q + HW'(1);
               if (half_q < HW'(NHALF)) begin
                  if (!half_q[0]) begin
                     sclk_o <= 1'b1;
                  end else begin
                     sclk_o  <= 1'b0;
                     shreg_q <= shreg_q << 1;
                  end
                  if (half_q == HW'(NHALF - 1))
                     slatch_o <= 1'b1;
               end else begin
                  slatch_o <= 1'b0;
                  active_q <= 1'b0;
                  done_o   <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_q + DIV_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/hook_reprog_seq.sv
module hook_reprog_seq
   import hrs_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 4,
   parameter int DIV_W     = 8,
   parameter int DLY_W     = 16,
   parameter int REF_W     = 20,
   parameter int MIN_HALF  = 10,
   parameter int FIRST_REG = 4,
   parameter int LAST_REG  = 14,
   parameter int RST_ADDR  = 15,
   parameter int MODE_ADDR = 13,
   parameter int HOLD_BIT  = 3,
   parameter int HF_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic [DLY_W-1:0]  hf_delay,
   input  logic              refresh_en,
   input  logic [REF_W-1:0]  refresh_interval,
   input  logic              ev_powerup,
   input  logic              ev_hook,
   input  logic [1:0]        hook_mode,
   input  logic              ev_flash_start,
   input  logic              ev_flash_end,
   input  logic              ev_brk_start,
   input  logic              ev_brk_end,
   output logic              sclk,
   output logic              sdata,
   output logic              slatch,
   output logic              busy
);
   localparam int NREG      = 1 << ADDR_W;
   localparam int FRAME_W   = ADDR_W + DATA_W;
   localparam int NRW       = LAST_REG - FIRST_REG + 1;
   localparam int LAST_STEP = NRW;
   localparam int STEP_W    = $clog2(LAST_STEP + 1);

   generate
      if (FIRST_REG < 0 || LAST_REG < FIRST_REG || LAST_REG >= NREG) begin : g_bad_range
         $error("hook_reprog_seq: register range outside the address space");
      end
      if (MODE_ADDR < FIRST_REG || MODE_ADDR > LAST_REG) begin : g_bad_mode
         $error("hook_reprog_seq: mode register must lie inside the rewrite range");
      end
      if (RST_ADDR >= NREG || HOLD_BIT >= DATA_W || HF_BIT >= DATA_W || HOLD_BIT == HF_BIT) begin : g_bad_bits
         $error("hook_reprog_seq: command address or mode bit positions invalid");
      end
      if (MIN_HALF < 1 || MIN_HALF > (1 << DIV_W)) begin : g_bad_div
         $error("hook_reprog_seq: MIN_HALF does not fit the divider width");
      end
   endgenerate

   // ---------------- shadow table ----------------
   logic [NREG-1:0][DATA_W-1:0] tbl;

   hrs_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (cfg_we),
      .addr_i (cfg_addr),
      .data_i (cfg_data),
      .tbl_o  (tbl)
   );

   // ---------------- refresh timer ----------------
   logic tick;

   hrs_tick #(.CNT_W(REF_W)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (refresh_en),
      .interval_i (refresh_interval),
      .fire_o     (tick)
   );

   // ---------------- event queue ----------------
   logic [PK_N-1:0] ev_set, ev_clr, pend, grant;
   logic            pend_any, take;
   logic            pend_hf_q;

   always_comb begin
      ev_set          = '0;
      ev_set[PK_PWR]  = ev_powerup;
      ev_set[PK_SET]  = ev_flash_start | ev_brk_start;
      ev_set[PK_CLR]  = ev_flash_end | ev_brk_end;
      ev_set[PK_HOOK] = ev_hook;
      ev_set[PK_REF]  = tick;

      ev_clr = '0;
      if (take) begin
         ev_clr = grant;
         if (grant[PK_PWR])
            ev_clr[PK_HOOK] = 1'b1;
      end
      if (ev_set[PK_SET])
         ev_clr[PK_CLR] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_hf_q <= 1'b0;
      else if (ev_powerup || ev_hook)
         pend_hf_q <= (hook_mode == HM_HANDSFREE);
   end

   hrs_evq #(.NK(PK_N)) u_evq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ev_set),
      .clr_i   (ev_clr),
      .pend_o  (pend),
      .grant_o (grant),
      .any_o   (pend_any)
   );

   // ---------------- sequencer ----------------
   seq_state_e        state_q;
   seq_kind_e         kind_q;
   logic [STEP_W-1:0] step_q;
   logic              tgt_hf_q, cur_hf_q, hold_q, hf_final_q;
   logic [DLY_W-1:0]  hf_cnt_q;
   logic              tx_start, tx_done;
   logic [FRAME_W-1:0] frame;
   logic [STEP_W-1:0] last_step;
   seq_kind_e         next_kind;

   assign take = (state_q == ST_IDLE) && pend_any;
   assign busy = (state_q != ST_IDLE);
   assign tx_start = (state_q == ST_LOAD);
   assign last_step = (kind_q == SK_SET) ? '0 : STEP_W'(LAST_STEP);

   always_comb begin
      if (grant[PK_PWR] || grant[PK_HOOK]) next_kind = SK_FULL;
      else if (grant[PK_SET])              next_kind = SK_SET;
      else if (grant[PK_CLR])              next_kind = SK_CLR;
      else                                 next_kind = SK_REFRESH;
   end

   function automatic logic [DATA_W-1:0] mode_val(input logic [DATA_W-1:0] base,
                                                  input logic hold, input logic hf);
      logic [DATA_W-1:0] v;
      v           = base;
      v[HOLD_BIT] = hold;
      v[HF_BIT]   = hf;
      return v;
   endfunction

   always_comb begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(FIRST_REG) + ADDR_W'(step_q) - ADDR_W'(1);
      if (hf_final_q) begin
         frame = {ADDR_W'(MODE_ADDR), mode_val(tbl[MODE_ADDR], 1'b0, 1'b1)};
      end else if (step_q == '0) begin
         case (kind_q)
            SK_SET:  frame = {ADDR_W'(MODE_ADDR), mode_val(tbl[MODE_ADDR], 1'b1, cur_hf_q)};
            SK_CLR:  frame = {ADDR_W'(MODE_ADDR), mode_val(tbl[MODE_ADDR], 1'b0, cur_hf_q)};
            default: frame = {ADDR_W'(RST_ADDR), DATA_W'(0)};
         endcase
      end else if (a == ADDR_W'(MODE_ADDR)) begin
         frame = {a, mode_val(tbl[MODE_ADDR], hold_q, cur_hf_q)};
      end else begin
         frame = {a, tbl[a]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         kind_q     <= SK_FULL;
         step_q     <= '0;
         tgt_hf_q   <= 1'b0;
         cur_hf_q   <= 1'b0;
         hold_q     <= 1'b0;
         hf_final_q <= 1'b0;
         hf_cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (take) begin
                  kind_q  <= next_kind;
                  step_q  <= (next_kind == SK_REFRESH) ? STEP_W'(1) : '0;
                  state_q <= ST_LOAD;
                  case (next_kind)
                     SK_FULL: begin
                        tgt_hf_q <= pend_hf_q;
                        cur_hf_q <= 1'b0;
                        hold_q   <= 1'b0;
                     end
                     SK_SET:  hold_q <= 1'b1;
                     SK_CLR:  hold_q <= 1'b0;
                     default: ;
                  endcase
               end
            end
            ST_LOAD: state_q <= ST_TX;
            ST_TX: begin
               if (tx_done) begin
                  if (hf_final_q) begin
                     hf_final_q <= 1'b0;
                     cur_hf_q   <= 1'b1;
                     state_q    <= ST_IDLE;
                  end else if (step_q == last_step) begin
                     if (kind_q == SK_FULL && tgt_hf_q) begin
                        hf_cnt_q <= '0;
                        state_q  <= ST_HFW;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     step_q  <= step_q + STEP_W'(1);
                     state_q <= ST_LOAD;
                  end
               end
            end
            ST_HFW: begin
               if (hf_cnt_q == hf_delay) begin
                  hf_final_q <= 1'b1;
                  state_q    <= ST_LOAD;
               end else begin
                  hf_cnt_q <= hf_cnt_q + DLY_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   hrs_sertx #(.FW(FRAME_W), .DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_i    (clk_div),
      .start_i  (tx_start),
      .frame_i  (frame),
      .sclk_o   (sclk),
      .sdata_o  (sdata),
      .slatch_o (slatch),
      .done_o   (tx_done)
   );
endmodule

// File: rtl/hrs_checker.sv
module hrs_checker #(
   parameter int DIV_W    = 8,
   parameter int MIN_HALF = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] clk_div,
   input logic             sclk,
   input logic             sdata,
   input logic             slatch,
   input logic             busy
);
   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(MIN_HALF - 1);

   logic [DIV_W:0] hi_len, lat_len, exp_len;

   assign exp_len = (clk_div < MIN_DIV) ? ({1'b0, MIN_DIV} + 1'b1) : ({1'b0, clk_div} + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len  <= '0;
         lat_len <= '0;
      end else begin
         hi_len  <= sclk   ? hi_len + 1'b1  : '0;
         lat_len <= slatch ? lat_len + 1'b1 : '0;
      end
   end

   // R9: serial lines quiet outside a sequence
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !slatch));

   // R5: latch strobe only while the clock is low
   p_latch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slatch |-> !sclk);

   // R5: data steady while the clock is high
   p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdata));

   // R6: clock high phase length
   p_half_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_len == exp_len));

   // R6: latch pulse length
   p_latch_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slatch) |-> (lat_len == exp_len));

   // R9: busy ends right after a latch pulse
   p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(slatch, 2));
endmodule

bind hook_reprog_seq hrs_checker #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clk_div (clk_div),
   .sclk    (sclk),
   .sdata   (sdata),
   .slatch  (slatch),
   .busy    (busy)
);

// File: tb/hook_reprog_seq_tb_top.sv
module hook_reprog_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0, cfg_data = '0;
   logic [7:0]  clk_div = 8'd9;
   logic [15:0] hf_delay = 16'd200;
   logic        refresh_en = 1'b0;
   logic [19:0] refresh_interval = 20'd3000;
   logic        ev_powerup = 0, ev_hook = 0, ev_flash_start = 0, ev_flash_end = 0;
   logic        ev_brk_start = 0, ev_brk_end = 0;
   logic [1:0]  hook_mode = 2'b01;
   logic        sclk, sdata, slatch, busy;

   always #5 clk = ~clk;

   hook_reprog_seq dut_i (.*);

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   always @(negedge clk) cyc = cyc + 1;

   // ---------------- frame monitor ----------------
   logic [7:0] cap [0:63];
   int         cap_rise [0:63];
   int         cap_lat [0:63];
   int         ncap = 0, bits = 0, bit_err = 0, half_err = 0, exp_half = 10;
   logic [7:0] sh_in;
   int         rise_t;

   always @(posedge sclk) begin
      if (bits == 0 && ncap < 64) cap_rise[ncap] = cyc;
      sh_in  = {sh_in[6:0], sdata};
      bits   = bits + 1;
      rise_t = cyc;
   end
   always @(negedge sclk) if (cyc - rise_t != exp_half) half_err++;
   always @(posedge slatch) begin
      if (bits != 8) bit_err++;
      if (ncap < 64) begin
         cap[ncap]     = sh_in;
         cap_lat[ncap] = cyc;
      end
      ncap++;
      bits = 0;
   end

   // ---------------- model ----------------
   logic [3:0] sh [0:15];
   logic [7:0] expf [0:63];
   int         nexp = 0;
   bit         m_hold = 0, m_hf = 0;

   function automatic logic [7:0] dfr(bit hold, bit hf);
      return {4'hD, hold, sh[13][2:1], hf};
   endfunction
   function automatic void push(logic [7:0] f);
      if (nexp < 64) expf[nexp] = f;
      nexp++;
   endfunction
   function automatic void regs(bit hold, bit hf);
      for (int a = 4; a <= 14; a++)
         push(a == 13 ? dfr(hold, hf) : {a[3:0], sh[a]});
   endfunction
   function automatic void e_full(bit hf);
      push(8'hF0);
      regs(0, 0);
      if (hf) push(dfr(0, 1));
      m_hold = 0; m_hf = hf;
   endfunction
   function automatic void e_set();
      push(dfr(1, m_hf)); m_hold = 1;
   endfunction
   function automatic void e_clr();
      m_hold = 0; push(dfr(0, m_hf)); regs(0, m_hf);
   endfunction
   function automatic void e_ref();
      regs(m_hold, m_hf);
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic clear_cap();
      ncap = 0; nexp = 0; bit_err = 0; half_err = 0;
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
   endtask

   task automatic fire_hook(logic [1:0] m);
      @(negedge clk) begin hook_mode = m; ev_hook = 1'b1; end
      @(negedge clk) ev_hook = 1'b0;
   endtask

   task automatic fire_pwr(logic [1:0] m);
      @(negedge clk) begin hook_mode = m; ev_powerup = 1'b1; end
      @(negedge clk) ev_powerup = 1'b0;
   endtask

   task automatic wait_idle();
      int q = 0;
      while (q < 4) begin
         @(negedge clk);
         if (busy) q = 0; else q++;
      end
   endtask

   task automatic wait_busy();
      while (!busy) @(negedge clk);
   endtask

   task automatic wr(int a, logic [3:0] d);
      @(negedge clk) begin cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_data = d; end
      @(negedge clk) cfg_we = 1'b0;
      sh[a] = d;
   endtask

   task automatic load_random();
      for (int a = 4; a <= 14; a++) wr(a, 4'($urandom));
   endtask

   task automatic set_div(int d);
      clk_div  = 8'(d);
      exp_half = (d < 9 ? 9 : d) + 1;
   endtask

   task automatic compare(string req);
      chk(ncap == nexp, req, "frame count", ncap, nexp);
      for (int i = 0; i < nexp && i < ncap && i < 64; i++)
         chk(cap[i] == expf[i], req, $sformatf("frame %0d", i), cap[i], expf[i]);
      chk(bit_err == 0, "R5", "frames without eight bits", bit_err, 0);
      chk(half_err == 0, "R6", "clock high phases of wrong length", half_err, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      void'($urandom(32'h5EED_1234));
      for (int a = 0; a < 16; a++) sh[a] = '0;
      repeat (3) @(negedge clk);
      chk(busy == 0 && sclk == 0 && slatch == 0 && sdata == 0, "R11", "outputs in reset",
          {busy, sclk, slatch, sdata}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy == 0 && sclk == 0 && slatch == 0 && sdata == 0, "R11", "outputs after reset",
          {busy, sclk, slatch, sdata}, 0);

      // R10: table writes send nothing
      clear_cap();
      load_random();
      repeat (20) @(negedge clk);
      chk(busy == 0 && ncap == 0, "R10", "writes started a sequence", ncap, 0);

      // R1: power-up in handset
      set_div(9);
      clear_cap(); e_full(0);
      fire_pwr(2'b01); wait_idle(); compare("R1");

      // R2: hook into handsfree with settling gap
      hf_delay = 16'd300;
      clear_cap(); e_full(1);
      fire_hook(2'b10); wait_idle(); compare("R2");
      if (ncap >= 13)
         chk(cap_rise[12] - cap_lat[11] >= 300 + 2 * exp_half, "R2", "settling gap",
             cap_rise[12] - cap_lat[11], 300 + 2 * exp_half);

      // R3/R4: flash start and end, current mode handsfree
      clear_cap(); e_set();
      pulse(ev_flash_start); wait_idle(); compare("R3");

      // R7: refresh while held, keeps hold bit and mode
      clear_cap(); e_ref();
      @(negedge clk) refresh_en = 1'b1;
      wait_busy(); wait_idle();
      @(negedge clk) refresh_en = 1'b0;
      compare("R7");

      clear_cap(); e_clr();
      pulse(ev_flash_end); wait_idle(); compare("R4");

      // R6: divider clamped and slow
      set_div(3);
      clear_cap(); e_set(); pulse(ev_brk_start); wait_idle(); compare("R6");
      set_div(20);
      clear_cap(); e_clr(); pulse(ev_brk_end); wait_idle(); compare("R6");
      set_div(9);

      // R10: changed value used by next sequence
      wr(7, ~sh[7]);
      clear_cap(); e_full(0);
      fire_hook(2'b00); wait_idle(); compare("R10");

      // R8: priority, merging, cancel of clear
      clear_cap();
      e_full(0); e_set(); e_full(0);
      fire_pwr(2'b01); wait_busy();
      fire_hook(2'b10);
      pulse(ev_flash_end);
      pulse(ev_flash_start);
      pulse(ev_brk_start);
      fire_hook(2'b01);
      wait_idle(); compare("R8");

      // R8: pending power-up absorbs pending hook, latest mode wins
      hf_delay = 16'd80;
      clear_cap();
      e_full(0); e_full(1);
      fire_hook(2'b01); wait_busy();
      fire_hook(2'b01);
      fire_pwr(2'b10);
      wait_idle(); compare("R8");

      // random mix
      for (int it = 0; it < 6; it++) begin
         int kind;
         load_random();
         set_div(9 + int'($urandom % 8));
         kind = int'($urandom % 4);
         hf_delay = 16'(50 + $urandom % 250);
         clear_cap();
         case (kind)
            0: begin e_full(0); fire_hook(2'b01); end
            1: begin e_full(1); fire_hook(2'b10); end
            2: begin e_set(); pulse(ev_flash_start); wait_idle(); e_clr(); pulse(ev_flash_end); end
            default: begin e_set(); pulse(ev_brk_start); wait_idle(); e_clr(); pulse(ev_brk_end); end
         endcase
         wait_idle();
         compare(kind < 2 ? "R1" : "R4");
      end

      // R9: quiet when idle
      repeat (10) @(negedge clk);
      chk(busy == 0 && sclk == 0 && slatch == 0, "R9", "idle lines", {busy, sclk, slatch}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule